// File: doc/BRIEF.md
# BCD Calendar Clock With Bus-Visible Time Bytes

This block keeps time of day and calendar date in packed BCD, from seconds up to the century, and exposes them as bytes at the top of a 15-bit byte-wide address space. A single-cycle tick input, nominally at 32,768 Hz, drives a prescaler that produces one second pulse per `TICKS_PER_SEC` ticks. The pulse advances a chain of BCD counters. The counters handle 24-hour time, day of week, month lengths and leap years (with the century taken into account), and a year rollover carries into the century.

The bus never reads the live counters. After each second pulse the block copies the counters into a bank of shadow bytes, and reads return those bytes. A control byte does three jobs. It can freeze the copy so that software reads a coherent snapshot. It can open a set mode in which software writes the shadow bytes and then commits them to the counters. It also holds a signed trim that lengthens or shortens some seconds in each calibration period.

The bus accepts an access on every cycle and has no back-pressure. A read request is answered with `bus_rvalid` exactly one cycle later, and the requester must take the data in that cycle. There is no ready signal at either end.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset the time bytes read as seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00 and century 0x20, and the control byte reads as 0x00.
- R2: The byte map is: 0x7FF1 century, 0x7FF8 control, 0x7FF9 seconds, 0x7FFA minutes, 0x7FFB hours, 0x7FFC day of week, 0x7FFD date, 0x7FFE month, 0x7FFF year. The seconds counter advances once per `TICKS_PER_SEC` ticks, however the ticks are spaced. The shadow bytes take the new value on the clock edge after the counter changes.
- R3: Seconds and minutes roll from 0x59 to 0x00 and hours from 0x23 to 0x00. A day rollover steps the day of week, which wraps from 7 to 1. Month wraps from 0x12 to 0x01. Year 0x99 goes to 0x00 and increments the century, and century 0x99 wraps to 0x00.
- R4: April, June, September and November have 30 days, and the other months except February have 31. February has 29 days when the year is divisible by four and not 00, or when the year is 00 and the century is divisible by four. Otherwise it has 28 days.
- R5: While control bit 0 (freeze) is 1, the shadow bytes do not change on a second boundary. After the bit is cleared, they stay unchanged until the next second pulse and then take the live counters.
- R6: While control bit 1 (set) is 1, writes to the time bytes land in the shadow bytes and read back. A control write that clears bit 1 while it is set loads all eight counters from the shadow bytes in that cycle and restarts the tick prescaler from zero.
- R7: Writes to time bytes while control bit 1 is 0 change nothing visible.
- R8: Control bits [7:3] hold a trim magnitude M and bit 2 its sign (1 = faster). The first M seconds of every `CAL_PERIOD`-second period last one tick fewer when the sign is 1, or one tick more when it is 0. All other seconds last `TICKS_PER_SEC` ticks.
- R9: A read with an address from 0x7FF0 up returns `bus_rvalid` = 1 one cycle later, with the addressed byte on `bus_rdata`. Unmapped addresses in that window read 0x00. A read below 0x7FF0 gives `bus_rvalid` = 0 and `bus_rdata` = 0x00.
- R10: A field loaded with a value above its legal maximum (for example seconds 0x75 or date 0x35) goes to its lowest legal value at its next increment and carries into the next field.
- R11: The control byte reads back the last value written to 0x7FF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse per oscillator period |
| bus_addr | input | 15 | Byte address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after an in-window read |

## Verification
The assertions assume that `tick_32k` is a one-cycle pulse synchronous to `clk` and that every bus input holds a known value from reset onward. They also assume the trim magnitude stays below `CAL_PERIOD` whenever a fixed period shape is expected. The stimulus changes inputs only on the falling clock edge and holds them at zero when idle. It loads only values whose BCD digits are each 0 to 9. It keeps ticks off while setting the time, so that the second boundaries fall at known tick counts. The ticks come both back to back and with gaps, so that the prescaler is tested independently of tick spacing.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [14:0] WIN_BASE = 15'h7FF0;
  localparam logic [14:0] A_CEN    = 15'h7FF1;
  localparam logic [14:0] A_CTRL   = 15'h7FF8;
  localparam logic [14:0] A_SEC    = 15'h7FF9;
  localparam logic [14:0] A_MIN    = 15'h7FFA;
  localparam logic [14:0] A_HR     = 15'h7FFB;
  localparam logic [14:0] A_DOW    = 15'h7FFC;
  localparam logic [14:0] A_DATE   = 15'h7FFD;
  localparam logic [14:0] A_MON    = 15'h7FFE;
  localparam logic [14:0] A_YR     = 15'h7FFF;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{cen: 8'h20, yr: 8'h00, mon: 8'h01,
                                     date: 8'h01, dow: 8'h01, hr: 8'h00,
                                     min: 8'h00, sec: 8'h00};

  // next BCD value; anything at or above top restarts at first
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] first);
    if (v >= top) return first;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  // two-digit BCD value divisible by four
  function automatic logic bcd_div4(input logic [7:0] v);
    if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
    if (yr == 8'h00) return bcd_div4(cen);
    return bcd_div4(yr);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CAL_PERIOD    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [4:0] cal_mag,
  input  logic       cal_fast,
  output logic       sec_pulse
);
  localparam int CW = $clog2(TICKS_PER_SEC + 2);
  localparam int PW = $clog2(CAL_PERIOD);
  localparam logic [CW-1:0] NOM_LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [PW-1:0] PER_LAST = PW'(CAL_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic [PW-1:0] per_q;
  logic          trim;

  always_comb begin
    trim = int'(per_q) < int'(cal_mag);
    last = NOM_LAST;
    if (trim) last = cal_fast ? NOM_LAST - CW'(1) : NOM_LAST + CW'(1);
  end

  assign sec_pulse = tick && !load && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q >= last) begin
        cnt_q <= '0;
        per_q <= (per_q == PER_LAST) ? '0 : per_q + PW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NOM_LAST + CW'(1));

  // R2
  pulse_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> cnt_q == '0);

  // R6
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == '0);
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_pulse,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now_q
);
  rtc_time_t  nxt;
  logic [7:0] last_day;
  logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    nxt      = now_q;
    last_day = month_last(now_q.mon, is_leap(now_q.yr, now_q.cen));
    c_min    = now_q.sec >= 8'h59;
    c_hr     = c_min && (now_q.min >= 8'h59);
    c_day    = c_hr && (now_q.hr >= 8'h23);
    c_mon    = c_day && (now_q.date >= last_day);
    c_yr     = c_mon && (now_q.mon >= 8'h12);
    c_cen    = c_yr && (now_q.yr >= 8'h99);
    nxt.sec  = bcd_step(now_q.sec, 8'h59, 8'h00);
    if (c_min) nxt.min  = bcd_step(now_q.min, 8'h59, 8'h00);
    if (c_hr)  nxt.hr   = bcd_step(now_q.hr, 8'h23, 8'h00);
    if (c_day) nxt.dow  = bcd_step(now_q.dow, 8'h07, 8'h01);
    if (c_day) nxt.date = bcd_step(now_q.date, last_day, 8'h01);
    if (c_mon) nxt.mon  = bcd_step(now_q.mon, 8'h12, 8'h01);
    if (c_yr)  nxt.yr   = bcd_step(now_q.yr, 8'h99, 8'h00);
    if (c_cen) nxt.cen  = bcd_step(now_q.cen, 8'h99, 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         now_q <= TIME_RST;
    else if (load)      now_q <= load_val;
    else if (sec_pulse) now_q <= nxt;
  end

  // R6
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> now_q == $past(load_val));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !load && now_q.sec == 8'h59) |=> now_q.sec == 8'h00);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !load) |=> $stable(now_q));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [14:0] addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  input  rtc_time_t   now,
  input  logic        sec_pulse,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output rtc_time_t   shadow_q,
  output logic        load,
  output logic [4:0]  cal_mag,
  output logic        cal_fast
);
  logic [7:0] ctrl_q;
  logic [7:0] rd_mux;
  logic       refresh_q;
  logic       freeze, set_mode, in_win, ctrl_wr;

  assign freeze   = ctrl_q[0];
  assign set_mode = ctrl_q[1];
  assign cal_fast = ctrl_q[2];
  assign cal_mag  = ctrl_q[7:3];
  assign in_win   = addr >= WIN_BASE;
  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign load     = ctrl_wr && set_mode && !wdata[1];

  always_comb begin
    case (addr)
      A_CEN:   rd_mux = shadow_q.cen;
      A_CTRL:  rd_mux = ctrl_q;
      A_SEC:   rd_mux = shadow_q.sec;
      A_MIN:   rd_mux = shadow_q.min;
      A_HR:    rd_mux = shadow_q.hr;
      A_DOW:   rd_mux = shadow_q.dow;
      A_DATE:  rd_mux = shadow_q.date;
      A_MON:   rd_mux = shadow_q.mon;
      A_YR:    rd_mux = shadow_q.yr;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= 8'h00;
      refresh_q <= 1'b0;
      rvalid    <= 1'b0;
      rdata     <= 8'h00;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      refresh_q <= sec_pulse;
      rvalid    <= rd_en && in_win;
      rdata     <= (rd_en && in_win) ? rd_mux : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= TIME_RST;
    end else if (refresh_q && !freeze && !set_mode) begin
      shadow_q <= now;
    end else if (wr_en && set_mode) begin
      case (addr)
        A_CEN:  shadow_q.cen  <= wdata;
        A_SEC:  shadow_q.sec  <= wdata;
        A_MIN:  shadow_q.min  <= wdata;
        A_HR:   shadow_q.hr   <= wdata;
        A_DOW:  shadow_q.dow  <= wdata;
        A_DATE: shadow_q.date <= wdata;
        A_MON:  shadow_q.mon  <= wdata;
        A_YR:   shadow_q.yr   <= wdata;
        default: ;
      endcase
    end
  end

  // R9
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_en));

  // R9
  out_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_win) |=> (!rvalid && rdata == 8'h00));

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable(shadow_q));

  // R7
  no_set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_mode && !refresh_q) |=> $stable(shadow_q));
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CAL_PERIOD    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_32k,
  input  logic [14:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_rvalid
);
  rtc_time_t  now;
  rtc_time_t  shadow;
  logic       sec_pulse;
  logic       load;
  logic [4:0] cal_mag;
  logic       cal_fast;

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .CAL_PERIOD   (CAL_PERIOD)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_32k),
    .load     (load),
    .cal_mag  (cal_mag),
    .cal_fast (cal_fast),
    .sec_pulse(sec_pulse)
  );

  rtc_counters u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_pulse(sec_pulse),
    .load     (load),
    .load_val (shadow),
    .now_q    (now)
  );

  rtc_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .wdata    (bus_wdata),
    .now      (now),
    .sec_pulse(sec_pulse),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid),
    .shadow_q (shadow),
    .load     (load),
    .cal_mag  (cal_mag),
    .cal_fast (cal_fast)
  );
endmodule

// File: tb/test_rtc_calendar_top.sv
module test_rtc_calendar_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;
  localparam int CP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [14:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_top #(.TICKS_PER_SEC(TPS), .CAL_PERIOD(CP)) i_rtc_calendar_top (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  // ---------------- behavioural reference ----------------
  int         c_sec, c_min, c_hr, c_dow, c_date, c_mon, c_yr, c_cen;
  logic [7:0] msh [16];
  logic [7:0] mctrl;
  bit         mrefresh;
  int         pcnt, per;
  bit         m_rvalid;
  logic [7:0] m_rdata;

  function automatic logic [7:0] tobcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int todec(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(int m, int y, int c);
    bit lp;
    lp = (y == 0) ? (c % 4 == 0) : (y % 4 == 0);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] mbyte(logic [3:0] i);
    if (i == 4'd8) return mctrl;
    if (i == 4'd1 || i >= 4'd9) return msh[i];
    return 8'h00;
  endfunction

  task automatic m_advance();
    if (c_sec >= 59) begin
      c_sec = 0;
      if (c_min >= 59) begin
        c_min = 0;
        if (c_hr >= 23) begin
          c_hr = 0;
          c_dow = (c_dow >= 7) ? 1 : c_dow + 1;
          if (c_date >= mdays(c_mon, c_yr, c_cen)) begin
            c_date = 1;
            if (c_mon >= 12) begin
              c_mon = 1;
              if (c_yr >= 99) begin
                c_yr = 0;
                c_cen = (c_cen >= 99) ? 0 : c_cen + 1;
              end else c_yr++;
            end else c_mon++;
          end else c_date++;
        end else c_hr++;
      end else c_min++;
    end else c_sec++;
  endtask

  task automatic m_snapshot();
    msh[1] = tobcd(c_cen);  msh[9] = tobcd(c_sec);  msh[10] = tobcd(c_min);
    msh[11] = tobcd(c_hr);  msh[12] = tobcd(c_dow); msh[13] = tobcd(c_date);
    msh[14] = tobcd(c_mon); msh[15] = tobcd(c_yr);
  endtask

  always @(posedge clk) begin
    int  last;
    bit  secp, ld;
    if (!rst_n) begin
      c_sec = 0; c_min = 0; c_hr = 0; c_dow = 1; c_date = 1; c_mon = 1;
      c_yr = 0; c_cen = 20;
      for (int i = 0; i < 16; i++) msh[i] = 8'h00;
      m_snapshot();
      mctrl = 8'h00; mrefresh = 0; pcnt = 0; per = 0;
      m_rvalid = 0; m_rdata = 8'h00;
    end else begin
      ld = bus_wr && bus_addr == 15'h7FF8 && mctrl[1] && !bus_wdata[1];
      last = TPS - 1;
      if (per < int'(mctrl[7:3])) last = mctrl[2] ? TPS - 2 : TPS;
      secp = tick && !ld && (pcnt >= last);
      m_rvalid = bus_rd && bus_addr >= 15'h7FF0;
      m_rdata = m_rvalid ? mbyte(bus_addr[3:0]) : 8'h00;
      if (mrefresh && !mctrl[0] && !mctrl[1]) m_snapshot();
      else if (bus_wr && mctrl[1] && bus_addr >= 15'h7FF0 &&
               (bus_addr[3:0] == 4'd1 || bus_addr[3:0] >= 4'd9))
        msh[bus_addr[3:0]] = bus_wdata;
      if (bus_wr && bus_addr == 15'h7FF8) mctrl = bus_wdata;
      mrefresh = secp;
      if (ld) begin
        c_cen = todec(msh[1]);  c_sec = todec(msh[9]);  c_min = todec(msh[10]);
        c_hr = todec(msh[11]);  c_dow = todec(msh[12]); c_date = todec(msh[13]);
        c_mon = todec(msh[14]); c_yr = todec(msh[15]);
        pcnt = 0;
      end else begin
        if (secp) m_advance();
        if (tick) begin
          if (pcnt >= last) begin
            pcnt = 0;
            per = (per + 1) % CP;
          end else pcnt++;
        end
      end
    end
  end

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rvalid !== m_rvalid || bus_rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s model compare: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                 cur_req, bus_rvalid, bus_rdata, m_rvalid, m_rdata);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_write(logic [14:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d; bus_rd = 0; tick = 0;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd_chk(logic [14:0] a, logic [7:0] exp, bit exp_v, string req);
    cur_req = req;
    @(negedge clk); bus_rd = 1; bus_addr = a; bus_wr = 0; tick = 0;
    @(negedge clk); bus_rd = 0;
    checks++;
    if (bus_rvalid !== exp_v || bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
               req, a, bus_rvalid, bus_rdata, exp_v, exp);
    end
  endtask

  task automatic run(int n, int gap, logic [14:0] pa, string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (i % (gap + 1)) == 0;
      bus_rd = 1; bus_addr = pa; bus_wr = 0;
    end
    @(negedge clk); tick = 0; bus_rd = 0;
  endtask

  task automatic set_time(logic [7:0] cen, yr, mon, date, dow, hr, mn, sc);
    bus_write(15'h7FF8, 8'h02);
    bus_write(15'h7FF1, cen);  bus_write(15'h7FFF, yr);
    bus_write(15'h7FFE, mon);  bus_write(15'h7FFD, date);
    bus_write(15'h7FFC, dow);  bus_write(15'h7FFB, hr);
    bus_write(15'h7FFA, mn);   bus_write(15'h7FF9, sc);
    bus_write(15'h7FF8, 8'h00);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R11 control readback, R9 window rules
    rd_chk(15'h7FF9, 8'h00, 1, "R1");
    rd_chk(15'h7FFA, 8'h00, 1, "R1");
    rd_chk(15'h7FFB, 8'h00, 1, "R1");
    rd_chk(15'h7FFC, 8'h01, 1, "R1");
    rd_chk(15'h7FFD, 8'h01, 1, "R1");
    rd_chk(15'h7FFE, 8'h01, 1, "R1");
    rd_chk(15'h7FFF, 8'h00, 1, "R1");
    rd_chk(15'h7FF1, 8'h20, 1, "R1");
    rd_chk(15'h7FF8, 8'h00, 1, "R11");
    rd_chk(15'h7FF0, 8'h00, 1, "R9");
    rd_chk(15'h7FF5, 8'h00, 1, "R9");
    rd_chk(15'h1234, 8'h00, 0, "R9");

    // R2 counting with back-to-back and gapped ticks
    run(40, 0, 15'h7FF9, "R2");
    rd_chk(15'h7FF9, 8'h10, 1, "R2");
    run(40, 1, 15'h7FF9, "R2");
    rd_chk(15'h7FF9, 8'h15, 1, "R2");

    // R7 writes without set mode are ignored
    bus_write(15'h7FF9, 8'h33);
    rd_chk(15'h7FF9, 8'h15, 1, "R7");

    // R6 set, readback, load, prescaler restart; R3 full rollover
    run(2, 0, 15'h7FF9, "R6");
    bus_write(15'h7FF8, 8'h02);
    bus_write(15'h7FF9, 8'h59);
    rd_chk(15'h7FF9, 8'h59, 1, "R6");
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    run(3, 0, 15'h7FF9, "R6");
    rd_chk(15'h7FF9, 8'h59, 1, "R6");
    run(1, 0, 15'h7FF9, "R3");
    rd_chk(15'h7FF9, 8'h00, 1, "R3");
    rd_chk(15'h7FFA, 8'h00, 1, "R3");
    rd_chk(15'h7FFB, 8'h00, 1, "R3");
    rd_chk(15'h7FFC, 8'h01, 1, "R3");
    rd_chk(15'h7FFD, 8'h01, 1, "R3");
    rd_chk(15'h7FFE, 8'h01, 1, "R3");
    rd_chk(15'h7FFF, 8'h00, 1, "R3");
    rd_chk(15'h7FF1, 8'h21, 1, "R3");
    set_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    run(4, 0, 15'h7FF9, "R3");
    rd_chk(15'h7FF1, 8'h00, 1, "R3");
    rd_chk(15'h7FFC, 8'h04, 1, "R3");

    // R4 month lengths and leap rule
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    run(4, 0, 15'h7FFD, "R4");
    rd_chk(15'h7FFD, 8'h29, 1, "R4");
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    run(4, 0, 15'h7FFD, "R4");
    rd_chk(15'h7FFD, 8'h29, 1, "R4");
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    run(4, 0, 15'h7FFD, "R4");
    rd_chk(15'h7FFD, 8'h01, 1, "R4");
    rd_chk(15'h7FFE, 8'h03, 1, "R4");
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    run(4, 0, 15'h7FFD, "R4");
    rd_chk(15'h7FFD, 8'h01, 1, "R4");
    rd_chk(15'h7FFE, 8'h05, 1, "R4");

    // R5 freeze then resume at next second
    bus_write(15'h7FF8, 8'h01);
    run(12, 0, 15'h7FF9, "R5");
    rd_chk(15'h7FF9, 8'h00, 1, "R5");
    bus_write(15'h7FF8, 8'h00);
    rd_chk(15'h7FF9, 8'h00, 1, "R5");
    run(4, 0, 15'h7FF9, "R5");
    rd_chk(15'h7FF9, 8'h04, 1, "R5");

    bus_write(15'h7FFA, 8'h42);
    rd_chk(15'h7FFA, 8'h00, 1, "R7");

    // R10 out-of-range values wrap at next increment
    set_time(8'h20, 8'h30, 8'h01, 8'h35, 8'h02, 8'h23, 8'h59, 8'h75);
    run(4, 0, 15'h7FF9, "R10");
    rd_chk(15'h7FF9, 8'h00, 1, "R10");
    rd_chk(15'h7FFA, 8'h00, 1, "R10");
    rd_chk(15'h7FFD, 8'h01, 1, "R10");
    rd_chk(15'h7FFE, 8'h02, 1, "R10");

    // R8 calibration, both signs, compared cycle by cycle
    bus_write(15'h7FF8, 8'h14);
    rd_chk(15'h7FF8, 8'h14, 1, "R11");
    run(64, 0, 15'h7FF9, "R8");
    run(60, 2, 15'h7FF9, "R8");
    bus_write(15'h7FF8, 8'h18);
    run(64, 0, 15'h7FF9, "R8");
    rd_chk(15'h7FF8, 8'h18, 1, "R11");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule